// File: doc/BRIEF.md
# Per-Channel Change Detection Unit

This block watches a parallel bus of digital input channels and reports when any of them makes a transition it has been told to care about. The inputs are sampled once per period of an external sample clock. That sample clock is brought into the block's own reference clock domain, and either its rising or its falling edge can serve as the sample point. Each new sample is compared with the one before it, so detection resolves to one sample-clock period.

Every channel has its own sensitivity, set by two bit masks: a rise-enable and a fall-enable. With both bits clear the channel is ignored. With one bit set it reacts to that edge only. With both set it reacts to either edge.

A qualifying sample does two things. It fires a single event pulse whose width is counted on the reference clock, using one of two programmed counts chosen by the sample-rate range. It also offers the new input word, together with the mask of channels that qualified, on a valid/ready capture port. Detection only runs after an arm request has raised the ready-for-start indication and a start request has followed it.

Top module: `change_detect_unit`

## Requirements
- R1: Out of reset, `evt_pulse`, `cap_valid` and `ready_for_start` are all low.
- R2: `arm` in the idle state raises `ready_for_start`. `go` is ignored unless the unit is armed. `go` while armed drops `ready_for_start` and starts detection. `halt` returns the unit to idle and ends detection. Priority is halt, then go, then arm.
- R3: The first sample taken after detection starts only sets the reference word and never produces an event.
- R4: Channel i reports a rise when its sampled value goes from 0 to 1 between two successive samples and `rise_en[i]` is 1. It reports a fall when the value goes from 1 to 0 and `fall_en[i]` is 1. Setting both bits selects either edge.
- R5: A channel with both enable bits at 0 never causes an event or a capture, whatever its input does.
- R6: With `edge_sel` = 0 the inputs are sampled on the rising edge of `smp_clk`. With `edge_sel` = 1 they are sampled on its falling edge.
- R7: Any number of qualifying channels in the same sample produce exactly one pulse. `cap_data` carries the whole sampled word and `cap_mask` has a 1 for every channel that qualified.
- R8: The event pulse stays high for `pw_slow` reference-clock cycles when `rate_fast` = 0, and for `pw_fast` cycles when `rate_fast` = 1 (widths of at least 1). A new event during a pulse reloads the count, so the pulse stretches to end that many cycles after the new event.
- R9: Once `cap_valid` is high, `cap_data` and `cap_mask` stay unchanged until a cycle with `cap_ready` high. A detection that arrives while the slot is still held is dropped from capture, but its event pulse is still produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_clk | input | 1 | External sample clock, asynchronous |
| din | input | WIDTH | Channel inputs |
| rise_en | input | WIDTH | Per-channel rising-edge enable |
| fall_en | input | WIDTH | Per-channel falling-edge enable |
| edge_sel | input | 1 | 0: sample on rising smp_clk edge, 1: on falling edge |
| rate_fast | input | 1 | Selects the fast-rate pulse width |
| pw_slow | input | CNT_W | Pulse width in clk cycles, slow rate |
| pw_fast | input | CNT_W | Pulse width in clk cycles, fast rate |
| arm | input | 1 | Arm request |
| go | input | 1 | Start trigger |
| halt | input | 1 | Return to idle |
| ready_for_start | output | 1 | High while armed and waiting for go |
| evt_pulse | output | 1 | Change-detection event pulse |
| cap_valid | output | 1 | Capture slot holds a word |
| cap_ready | input | 1 | Consumer takes the capture this cycle |
| cap_data | output | WIDTH | Sampled word at the detection |
| cap_mask | output | WIDTH | Channels that qualified |

## Verification
The assertions assume that `din` is stable across each sample-clock edge and that each level of `smp_clk` lasts several reference-clock cycles, so one edge gives one aligned sample. The bench meets this by building every sample-clock period from fixed reference-clock counts and changing data only on the reference clock's falling edge, well away from any `smp_clk` edge. Programmed widths stay nonzero. The spacing between samples exceeds the pulse width except in the one deliberate reload case.

// File: rtl/cdu_pkg.sv
package cdu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } cdu_state_e;
endpackage

// File: rtl/cdu_sync.sv
module cdu_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_clk,
  input  logic [WIDTH-1:0] din,
  input  logic             edge_sel,
  output logic             strobe,
  output logic [WIDTH-1:0] word
);
  logic [STAGES:0]    clk_pipe;
  logic [WIDTH-1:0]   dat_pipe [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) clk_pipe <= '0;
    else        clk_pipe <= {clk_pipe[STAGES-1:0], smp_clk};
  end

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_dat
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) dat_pipe[g] <= '0;
          else        dat_pipe[g] <= din;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rst_n) dat_pipe[g] <= '0;
          else        dat_pipe[g] <= dat_pipe[g-1];
        end
      end
    end
  endgenerate

  logic now_lvl, old_lvl;
  assign now_lvl = clk_pipe[STAGES-1];
  assign old_lvl = clk_pipe[STAGES];
  assign strobe  = edge_sel ? (old_lvl & ~now_lvl) : (now_lvl & ~old_lvl);
  assign word    = dat_pipe[STAGES-1];

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe); // R6
endmodule

// File: rtl/cdu_ctrl.sv
module cdu_ctrl
  import cdu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic go,
  input  logic halt,
  output logic running,
  output logic ready_for_start
);
  cdu_state_e state, nxt;

  always_comb begin
    nxt = state;
    if (halt) nxt = ST_IDLE;
    else begin
      unique case (state)
        ST_IDLE:  if (arm) nxt = ST_ARMED;
        ST_ARMED: if (go)  nxt = ST_RUN;
        ST_RUN:   nxt = ST_RUN;
        default:  nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assign running         = (state == ST_RUN);
  assign ready_for_start = (state == ST_ARMED);

  AST_RUN_AFTER_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> $past(ready_for_start) && $past(go)); // R2
  AST_HALT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !running && !ready_for_start); // R2
endmodule

// File: rtl/cdu_detect.sv
module cdu_detect #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic             running,
  input  logic [WIDTH-1:0] word,
  input  logic [WIDTH-1:0] rise_en,
  input  logic [WIDTH-1:0] fall_en,
  output logic             hit,
  output logic [WIDTH-1:0] hit_mask
);
  logic [WIDTH-1:0] prev;
  logic             base_ok;

  genvar c;
  generate
    for (c = 0; c < WIDTH; c++) begin : g_chan
      logic went_up, went_dn;
      assign went_up     = ~prev[c] &  word[c];
      assign went_dn     =  prev[c] & ~word[c];
      assign hit_mask[c] = (went_up & rise_en[c]) | (went_dn & fall_en[c]);
    end
  endgenerate

  assign hit = strobe && running && base_ok && (|hit_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev    <= '0;
      base_ok <= 1'b0;
    end else if (!running) begin
      base_ok <= 1'b0;
    end else if (strobe) begin
      prev    <= word;
      base_ok <= 1'b1;
    end
  end

  AST_NO_HIT_ON_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && running && !base_ok) |-> !hit); // R3
endmodule

// File: rtl/cdu_pulse.sv
module cdu_pulse #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             rate_fast,
  input  logic [CNT_W-1:0] pw_slow,
  input  logic [CNT_W-1:0] pw_fast,
  output logic             pulse
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] width;

  assign width = rate_fast ? pw_fast : pw_slow;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= width;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign pulse = (cnt != '0);

  AST_PULSE_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load && width != '0) |=> pulse); // R8
endmodule

// File: rtl/cdu_capture.sv
module cdu_capture #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic [WIDTH-1:0] word,
  input  logic [WIDTH-1:0] mask,
  output logic             cap_valid,
  input  logic             cap_ready,
  output logic [WIDTH-1:0] cap_data,
  output logic [WIDTH-1:0] cap_mask
);
  logic take;
  assign take = hit && (!cap_valid || cap_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_valid <= 1'b0;
      cap_data  <= '0;
      cap_mask  <= '0;
    end else if (take) begin
      cap_valid <= 1'b1;
      cap_data  <= word;
      cap_mask  <= mask;
    end else if (cap_ready) begin
      cap_valid <= 1'b0;
    end
  end

  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && !cap_ready) |=> cap_valid && $stable(cap_data) && $stable(cap_mask)); // R9
  AST_CAP_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !cap_valid) |=> cap_valid); // R7
endmodule

// File: rtl/change_detect_unit.sv
module change_detect_unit #(
  parameter int WIDTH       = 32,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_clk,
  input  logic [WIDTH-1:0] din,
  input  logic [WIDTH-1:0] rise_en,
  input  logic [WIDTH-1:0] fall_en,
  input  logic             edge_sel,
  input  logic             rate_fast,
  input  logic [CNT_W-1:0] pw_slow,
  input  logic [CNT_W-1:0] pw_fast,
  input  logic             arm,
  input  logic             go,
  input  logic             halt,
  output logic             ready_for_start,
  output logic             evt_pulse,
  output logic             cap_valid,
  input  logic             cap_ready,
  output logic [WIDTH-1:0] cap_data,
  output logic [WIDTH-1:0] cap_mask
);
  logic             strobe;
  logic [WIDTH-1:0] word;
  logic             running;
  logic             hit;
  logic [WIDTH-1:0] hit_mask;

  cdu_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .smp_clk(smp_clk), .din(din),
    .edge_sel(edge_sel), .strobe(strobe), .word(word)
  );

  cdu_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .arm(arm), .go(go), .halt(halt),
    .running(running), .ready_for_start(ready_for_start)
  );

  cdu_detect #(.WIDTH(WIDTH)) u_detect (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .running(running),
    .word(word), .rise_en(rise_en), .fall_en(fall_en),
    .hit(hit), .hit_mask(hit_mask)
  );

  cdu_pulse #(.CNT_W(CNT_W)) u_pulse (
    .clk(clk), .rst_n(rst_n), .load(hit), .rate_fast(rate_fast),
    .pw_slow(pw_slow), .pw_fast(pw_fast), .pulse(evt_pulse)
  );

  cdu_capture #(.WIDTH(WIDTH)) u_cap (
    .clk(clk), .rst_n(rst_n), .hit(hit), .word(word), .mask(hit_mask),
    .cap_valid(cap_valid), .cap_ready(cap_ready),
    .cap_data(cap_data), .cap_mask(cap_mask)
  );

  AST_HIT_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> running && !ready_for_start); // R2
  AST_DONTCARE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((hit_mask & ~(rise_en | fall_en)) == '0)); // R5
endmodule

// File: tb/change_detect_unit_test.sv
`timescale 1ns/1ps
module change_detect_unit_test;
  localparam int W = 32;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_clk = 1'b0;
  logic [W-1:0] din = '0, rise_en = '0, fall_en = '0;
  logic edge_sel = 1'b0, rate_fast = 1'b0;
  logic [CW-1:0] pw_slow = 8'd7, pw_fast = 8'd3;
  logic arm = 1'b0, go = 1'b0, halt = 1'b0, cap_ready = 1'b0;
  logic ready_for_start, evt_pulse, cap_valid;
  logic [W-1:0] cap_data, cap_mask;

  int checks = 0, errors = 0;
  int npulses = 0, cur_w = 0, last_w = 0, cycles = 0;

  logic [W-1:0] prev_m = '0;
  logic base_m = 1'b0, run_m = 1'b0;
  logic slot_m = 1'b0;
  logic [W-1:0] slot_d = '0, slot_k = '0;

  always #10 clk = ~clk;

  change_detect_unit #(.WIDTH(W), .CNT_W(CW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .smp_clk(smp_clk), .din(din),
    .rise_en(rise_en), .fall_en(fall_en), .edge_sel(edge_sel),
    .rate_fast(rate_fast), .pw_slow(pw_slow), .pw_fast(pw_fast),
    .arm(arm), .go(go), .halt(halt), .ready_for_start(ready_for_start),
    .evt_pulse(evt_pulse), .cap_valid(cap_valid), .cap_ready(cap_ready),
    .cap_data(cap_data), .cap_mask(cap_mask)
  );

  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (evt_pulse) cur_w = cur_w + 1;
    else if (cur_w > 0) begin
      last_w = cur_w; npulses = npulses + 1; cur_w = 0;
    end
  end

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] qual_mask(input logic [W-1:0] p, input logic [W-1:0] n,
                                             input logic [W-1:0] re, input logic [W-1:0] fe);
    logic [W-1:0] m;
    for (int i = 0; i < W; i++)
      m[i] = ((p[i] == 1'b0) && (n[i] == 1'b1) && re[i]) ||
             ((p[i] == 1'b1) && (n[i] == 1'b0) && fe[i]);
    return m;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_sample(input logic [W-1:0] a, input logic [W-1:0] b);
    din = a; wait_clk(2);
    smp_clk = 1'b1; wait_clk(2);
    din = b; wait_clk(2);
    smp_clk = 1'b0; wait_clk(4);
    wait_clk(10);
  endtask

  // returns the model mask and advances the model
  function automatic logic [W-1:0] model_step(input logic [W-1:0] word);
    logic [W-1:0] m = '0;
    if (run_m) begin
      if (base_m) m = qual_mask(prev_m, word, rise_en, fall_en);
      base_m = 1'b1;
      prev_m = word;
    end
    if (m != '0 && !slot_m) begin
      slot_m = 1'b1; slot_d = word; slot_k = m;
    end
    return m;
  endfunction

  task automatic pop();
    cap_ready = 1'b1; wait_clk(1); cap_ready = 1'b0;
    slot_m = 1'b0;
  endtask

  task automatic sample_check(input string req, input logic [W-1:0] a,
                              input logic [W-1:0] b, input logic do_pop);
    int p0;
    logic [W-1:0] word, m;
    p0 = npulses;
    word = edge_sel ? b : a;
    drive_sample(a, b);
    m = model_step(word);
    check(req, W'(npulses - p0), (m != '0) ? W'(1) : W'(0));
    if (m != '0) check({req, " width R8"}, W'(last_w), W'(rate_fast ? pw_fast : pw_slow));
    check({req, " valid R9"}, W'(cap_valid), W'(slot_m));
    if (slot_m) begin
      check({req, " data R7"}, cap_data, slot_d);
      check({req, " mask R7"}, cap_mask, slot_k);
    end
    if (do_pop && slot_m) pop();
  endtask

  task automatic pulse_in(ref logic sig);
    sig = 1'b1; wait_clk(1); sig = 1'b0; wait_clk(1);
  endtask

  initial begin : watchdog
    wait (cycles > 100000);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [W-1:0] r;
    void'($urandom(32'h00C0FFEE));
    wait_clk(3);
    check("R1 evt", W'(evt_pulse), W'(0));
    check("R1 valid", W'(cap_valid), W'(0));
    check("R1 rfs", W'(ready_for_start), W'(0));
    rst_n = 1'b1; wait_clk(2);

    // R2: go while idle is ignored
    rise_en = '1; fall_en = '1;
    pulse_in(go);
    check("R2 go ignored rfs", W'(ready_for_start), W'(0));
    sample_check("R2 idle no event", 32'hFFFF_0000, 32'hFFFF_0000, 1'b1);
    sample_check("R2 idle no event", 32'h0000_FFFF, 32'h0000_FFFF, 1'b1);

    pulse_in(arm);
    check("R2 armed rfs", W'(ready_for_start), W'(1));
    sample_check("R2 armed no event", 32'h1234_5678, 32'h1234_5678, 1'b1);
    pulse_in(go); run_m = 1'b1; base_m = 1'b0;
    check("R2 run rfs low", W'(ready_for_start), W'(0));

    // R3: first sample is baseline
    sample_check("R3 baseline", 32'hA5A5_A5A5, 32'hA5A5_A5A5, 1'b1);
    // R4: modes
    rise_en = 32'h0000_00FF; fall_en = 32'h0000_FF00;
    sample_check("R4 rise", 32'hA5A5_A5FF, 32'hA5A5_A5FF, 1'b1);
    sample_check("R4 fall", 32'hA5A5_00FF, 32'hA5A5_00FF, 1'b1);
    sample_check("R4 wrong edge", 32'hA5A5_FF00, 32'hA5A5_FF00, 1'b1);
    // R5: don't care channels
    rise_en = 32'h0000_FFFF; fall_en = 32'h0000_FFFF;
    sample_check("R5 dont care", 32'h5A5A_FF00, 32'h5A5A_FF00, 1'b1);
    check("R5 no capture", W'(cap_valid), W'(0));
    // R7: many channels, one pulse
    rise_en = '1; fall_en = '1;
    sample_check("R7 multi", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    // R6: edge select
    edge_sel = 1'b0;
    sample_check("R6 rising edge", 32'h0000_0001, 32'h0000_0003, 1'b1);
    edge_sel = 1'b1;
    sample_check("R6 falling edge", 32'h0000_0001, 32'h0000_0007, 1'b1);
    edge_sel = 1'b0;
    // R8: fast width
    rate_fast = 1'b1;
    sample_check("R8 fast", 32'h0000_0000, 32'h0000_0000, 1'b1);
    rate_fast = 1'b0;
    // R9: back-pressure keeps first capture
    sample_check("R9 first", 32'h0000_0010, 32'h0000_0010, 1'b0);
    sample_check("R9 held", 32'h0000_0030, 32'h0000_0030, 1'b0);
    pop();
    check("R9 popped", W'(cap_valid), W'(0));
    // R8: reload stretches the pulse
    begin
      int p0;
      logic [W-1:0] m;
      pw_slow = 8'd40; p0 = npulses;
      drive_sample(32'h0000_0070, 32'h0000_0070); m = model_step(32'h0000_0070);
      drive_sample(32'h0000_00F0, 32'h0000_00F0); m = model_step(32'h0000_00F0);
      wait_clk(50);
      check("R8 reload count", W'(npulses - p0), W'(1));
      check("R8 reload width", W'(last_w), W'(60));
      pop();
      pw_slow = 8'd7;
    end
    // random phase
    for (int k = 0; k < 40; k++) begin
      rise_en = $urandom(); fall_en = $urandom();
      edge_sel = k[3]; rate_fast = k[2];
      r = ((k % 5) == 0) ? prev_m : $urandom();
      sample_check("R4 random", r, edge_sel ? r : r, k[0]);
    end
    if (slot_m) pop();
    // R2: halt ends detection
    pulse_in(halt); run_m = 1'b0;
    check("R2 halt rfs", W'(ready_for_start), W'(0));
    rise_en = '1; fall_en = '1;
    sample_check("R2 halted", ~prev_m, ~prev_m, 1'b1);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule